// File: doc/BRIEF.md
# Linked-List Multi-Queue Manager

The block keeps several FIFO queues in one shared slot memory. Each slot holds a 64-bit word and a next pointer. Each queue is a linked list that keeps a head pointer, a tail pointer and an element count. There is one queue per output link, four by default. A further list, the free pool, chains every unused slot. At reset, all slots sit in the free pool and every link queue is empty.

Two operations are supported. An enqueue names a link and carries a data word. It takes the slot at the head of the free pool, stores the word there and appends that slot to the link's tail. A dequeue names a link and returns the word at that link's head. It then hands the slot back to the tail of the free pool. A dequeue from an empty link reports a miss. An enqueue made while the free pool is empty reports a drop. In both cases nothing else changes.

Each operation passes through two stages. The first stage captures the list pointers. The second stage accesses the slot memory and writes the pointers back. The block accepts one operation per cycle. The first stage reads the pointer values that the second stage is writing in the same cycle, so an operation always sees the effect of the one issued just before it. The issuer must alternate enqueues and dequeues on consecutive cycles. A link sender serves the dequeue side in turn across the links.

Top module: `lq_mgr`

## Requirements
- R1: After reset, `link_empty` is all ones, `free_empty` is 0, and `deq_valid`, `deq_miss` and `enq_drop` are 0.
- R2: On each link, dequeues return words in the order in which they were enqueued.
- R3: Link queues are independent. An operation on one link never changes the contents or the empty flag of another link.
- R4: An operation sampled at rising edge k produces its single outcome pulse (`deq_valid`, `deq_miss` or `enq_drop`) for exactly one cycle from edge k+1. Without an operation, all three stay low.
- R5: A dequeue on a link whose queue is empty pulses `deq_miss`, not `deq_valid`. It leaves every queue and the free pool unchanged.
- R6: An enqueue while the free pool is empty pulses `enq_drop` and stores nothing. The queue contents that follow are exactly what they would be without that enqueue.
- R7: Exactly SLOTS words can be held across all links. `free_empty` is 1 exactly when SLOTS words are held.
- R8: A slot released by a dequeue can be used by a later enqueue, and `free_empty` clears after that dequeue.
- R9: A link's `link_empty` bit clears when its first word is enqueued. It sets again when its last word is dequeued.
- R10: An enqueue followed on the very next cycle by a dequeue of the same link returns the word just enqueued.
- R11: `op_kind` encodes 0 = enqueue and 1 = dequeue. `op_link` selects link 0 to NUM_LINKS-1. Operations on consecutive cycles must be of different kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 1 | 0 = enqueue, 1 = dequeue |
| op_link | input | $clog2(NUM_LINKS) | Target link queue |
| op_data | input | DATA_W | Word to store on enqueue |
| deq_valid | output | 1 | A dequeue returned a word |
| deq_miss | output | 1 | A dequeue found its link queue empty |
| deq_data | output | DATA_W | Word returned by the last successful dequeue |
| enq_drop | output | 1 | An enqueue was discarded because no slot was free |
| link_empty | output | NUM_LINKS | One bit per link, 1 when that queue holds nothing |
| free_empty | output | 1 | 1 when every slot is in use |

## Verification
The assertions assume that operations on consecutive cycles are of different kinds. They also assume that `op_valid` is low while reset is asserted. The pointer-conservation and single-element checks rely on this ordering. The stimulus inserts an idle cycle whenever it would otherwise issue two operations of the same kind. Dense runs are built strictly as enqueue/dequeue pairs. The bench predicts every outcome, word and flag from its own per-link FIFO model. It does this while filling the pool to overflow under several link distributions and while draining it port by port.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic {
    OP_ENQ = 1'b0,
    OP_DEQ = 1'b1
  } op_kind_e;
endpackage

// File: rtl/lq_slot_mem.sv
module lq_slot_mem #(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 64,
  parameter int PTR_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dwr_en,
  input  logic [PTR_W-1:0]  dwr_addr,
  input  logic [DATA_W-1:0] dwr_data,
  input  logic [PTR_W-1:0]  drd_addr,
  output logic [DATA_W-1:0] drd_data,
  input  logic              nwr_en,
  input  logic [PTR_W-1:0]  nwr_addr,
  input  logic [PTR_W-1:0]  nwr_val,
  input  logic [PTR_W-1:0]  nrd_addr,
  output logic [PTR_W-1:0]  nrd_val
);
  logic [DATA_W-1:0] word_q [SLOTS];
  logic [PTR_W-1:0]  link_q [SLOTS];

  // Data words: no reset, written under an explicit enable.
  always_ff @(posedge clk) begin
    if (dwr_en) word_q[dwr_addr] <= dwr_data;
  end

  // Next pointers: reset chains slot i to slot i+1.
  for (genvar i = 0; i < SLOTS; i++) begin : g_link
    logic hit;
    assign hit = nwr_en && (nwr_addr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   link_q[i] <= PTR_W'((i + 1) % SLOTS);
      else if (hit) link_q[i] <= nwr_val;
    end
  end

  assign drd_data = word_q[drd_addr];
  assign nrd_val  = link_q[nrd_addr];
endmodule

// File: rtl/lq_ptr_file.sv
module lq_ptr_file #(
  parameter int NUM_LISTS = 5,
  parameter int SLOTS     = 32,
  parameter int PTR_W     = $clog2(SLOTS),
  parameter int CNT_W     = $clog2(SLOTS + 1),
  parameter int LIDX_W    = $clog2(NUM_LISTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_en,
  input  logic [LIDX_W-1:0] lnk_idx,
  input  logic [PTR_W-1:0]  lnk_head,
  input  logic [PTR_W-1:0]  lnk_tail,
  input  logic [CNT_W-1:0]  lnk_cnt,
  input  logic              fre_en,
  input  logic [PTR_W-1:0]  fre_head,
  input  logic [PTR_W-1:0]  fre_tail,
  input  logic [CNT_W-1:0]  fre_cnt,
  output logic [PTR_W-1:0]  nx_head [NUM_LISTS],
  output logic [PTR_W-1:0]  nx_tail [NUM_LISTS],
  output logic [CNT_W-1:0]  nx_cnt  [NUM_LISTS],
  output logic [CNT_W-1:0]  cur_cnt [NUM_LISTS]
);
  localparam int POOL = NUM_LISTS - 1;

  logic [PTR_W-1:0] hd_q [NUM_LISTS];
  logic [PTR_W-1:0] tl_q [NUM_LISTS];
  logic [CNT_W-1:0] cn_q [NUM_LISTS];

  always_comb begin
    for (int i = 0; i < NUM_LISTS; i++) begin
      nx_head[i] = hd_q[i];
      nx_tail[i] = tl_q[i];
      nx_cnt[i]  = cn_q[i];
    end
    if (lnk_en) begin
      nx_head[lnk_idx] = lnk_head;
      nx_tail[lnk_idx] = lnk_tail;
      nx_cnt[lnk_idx]  = lnk_cnt;
    end
    if (fre_en) begin
      nx_head[POOL] = fre_head;
      nx_tail[POOL] = fre_tail;
      nx_cnt[POOL]  = fre_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LISTS; i++) begin
        hd_q[i] <= '0;
        tl_q[i] <= (i == POOL) ? PTR_W'(SLOTS - 1) : '0;
        cn_q[i] <= (i == POOL) ? CNT_W'(SLOTS) : '0;
      end
    end else if (lnk_en || fre_en) begin
      for (int i = 0; i < NUM_LISTS; i++) begin
        hd_q[i] <= nx_head[i];
        tl_q[i] <= nx_tail[i];
        cn_q[i] <= nx_cnt[i];
      end
    end
  end

  assign cur_cnt = cn_q;

  // Every slot is on exactly one list: counts add up to SLOTS.
  int unsigned total;
  always_comb begin
    total = 0;
    for (int i = 0; i < NUM_LISTS; i++) total = total + 32'(cn_q[i]);
  end

  p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    total == 32'(SLOTS));

  for (genvar g = 0; g < NUM_LISTS; g++) begin : g_chk
    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cn_q[g] == CNT_W'(1)) |-> (hd_q[g] == tl_q[g]));
    p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cn_q[g] <= CNT_W'(SLOTS));
  end
endmodule

// File: rtl/lq_mgr.sv
module lq_mgr #(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 32,
  parameter int DATA_W    = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic                         op_kind,
  input  logic [$clog2(NUM_LINKS)-1:0] op_link,
  input  logic [DATA_W-1:0]            op_data,
  output logic                         deq_valid,
  output logic                         deq_miss,
  output logic [DATA_W-1:0]            deq_data,
  output logic                         enq_drop,
  output logic [NUM_LINKS-1:0]         link_empty,
  output logic                         free_empty
);
  import lq_pkg::*;

  localparam int NUM_LISTS = NUM_LINKS + 1;
  localparam int POOL      = NUM_LINKS;
  localparam int PTR_W     = $clog2(SLOTS);
  localparam int CNT_W     = $clog2(SLOTS + 1);
  localparam int LIDX_W    = $clog2(NUM_LISTS);
  localparam int LNK_W     = $clog2(NUM_LINKS);

  // Pointer file views
  logic [PTR_W-1:0] nx_head [NUM_LISTS];
  logic [PTR_W-1:0] nx_tail [NUM_LISTS];
  logic [CNT_W-1:0] nx_cnt  [NUM_LISTS];
  logic [CNT_W-1:0] cur_cnt [NUM_LISTS];

  // Stage 1 registers: operation plus pointer snapshot
  logic              s1_vld;
  op_kind_e          s1_kind;
  logic [LNK_W-1:0]  s1_link;
  logic [DATA_W-1:0] s1_data;
  logic [PTR_W-1:0]  s1_lh, s1_lt, s1_fh, s1_ft;
  logic [CNT_W-1:0]  s1_lc, s1_fc;

  // Stage 2 controls
  logic              lnk_en, fre_en, dwr_en, nwr_en;
  logic [PTR_W-1:0]  lnk_head, lnk_tail, fre_head, fre_tail;
  logic [CNT_W-1:0]  lnk_cnt, fre_cnt;
  logic [PTR_W-1:0]  nwr_addr, nwr_val, nrd_addr, nrd_val;
  logic [DATA_W-1:0] drd_data;
  logic              hit_d, miss_d, drop_d;

  // Stage 1: the snapshot is taken from next-state values, so a
  // write-back from stage 2 in the same cycle is forwarded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= op_valid;
  end

  always_ff @(posedge clk) begin
    if (op_valid) begin
      s1_kind <= op_kind_e'(op_kind);
      s1_link <= op_link;
      s1_data <= op_data;
      s1_lh   <= nx_head[op_link];
      s1_lt   <= nx_tail[op_link];
      s1_lc   <= nx_cnt[op_link];
      s1_fh   <= nx_head[POOL];
      s1_ft   <= nx_tail[POOL];
      s1_fc   <= nx_cnt[POOL];
    end
  end

  // Stage 2: slot memory access and pointer write-back
  always_comb begin
    hit_d    = 1'b0;
    miss_d   = 1'b0;
    drop_d   = 1'b0;
    dwr_en   = 1'b0;
    nwr_en   = 1'b0;
    nwr_addr = s1_lt;
    nwr_val  = s1_fh;
    lnk_en   = 1'b0;
    lnk_head = s1_lh;
    lnk_tail = s1_lt;
    lnk_cnt  = s1_lc;
    fre_en   = 1'b0;
    fre_head = s1_fh;
    fre_tail = s1_ft;
    fre_cnt  = s1_fc;
    nrd_addr = (s1_kind == OP_ENQ) ? s1_fh : s1_lh;
    if (s1_vld) begin
      if (s1_kind == OP_ENQ) begin
        if (s1_fc == '0) begin
          drop_d = 1'b1;
        end else begin
          dwr_en   = 1'b1;
          lnk_en   = 1'b1;
          lnk_head = (s1_lc == '0) ? s1_fh : s1_lh;
          lnk_tail = s1_fh;
          lnk_cnt  = s1_lc + CNT_W'(1);
          fre_en   = 1'b1;
          fre_head = nrd_val;
          fre_cnt  = s1_fc - CNT_W'(1);
          if (s1_lc != '0) begin
            nwr_en   = 1'b1;
            nwr_addr = s1_lt;
            nwr_val  = s1_fh;
          end
        end
      end else begin
        if (s1_lc == '0) begin
          miss_d = 1'b1;
        end else begin
          hit_d    = 1'b1;
          lnk_en   = 1'b1;
          lnk_head = nrd_val;
          lnk_cnt  = s1_lc - CNT_W'(1);
          fre_en   = 1'b1;
          fre_head = (s1_fc == '0) ? s1_lh : s1_fh;
          fre_tail = s1_lh;
          fre_cnt  = s1_fc + CNT_W'(1);
          if (s1_fc != '0) begin
            nwr_en   = 1'b1;
            nwr_addr = s1_ft;
            nwr_val  = s1_lh;
          end
        end
      end
    end
  end

  lq_slot_mem #(.SLOTS(SLOTS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .dwr_en   (dwr_en),
    .dwr_addr (s1_fh),
    .dwr_data (s1_data),
    .drd_addr (s1_lh),
    .drd_data (drd_data),
    .nwr_en   (nwr_en),
    .nwr_addr (nwr_addr),
    .nwr_val  (nwr_val),
    .nrd_addr (nrd_addr),
    .nrd_val  (nrd_val)
  );

  lq_ptr_file #(.NUM_LISTS(NUM_LISTS), .SLOTS(SLOTS), .PTR_W(PTR_W),
                .CNT_W(CNT_W), .LIDX_W(LIDX_W)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .lnk_en   (lnk_en),
    .lnk_idx  (LIDX_W'(s1_link)),
    .lnk_head (lnk_head),
    .lnk_tail (lnk_tail),
    .lnk_cnt  (lnk_cnt),
    .fre_en   (fre_en),
    .fre_head (fre_head),
    .fre_tail (fre_tail),
    .fre_cnt  (fre_cnt),
    .nx_head  (nx_head),
    .nx_tail  (nx_tail),
    .nx_cnt   (nx_cnt),
    .cur_cnt  (cur_cnt)
  );

  // Outcome registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deq_valid <= 1'b0;
      deq_miss  <= 1'b0;
      enq_drop  <= 1'b0;
    end else begin
      deq_valid <= hit_d;
      deq_miss  <= miss_d;
      enq_drop  <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit_d) deq_data <= drd_data;
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_empty
    assign link_empty[l] = (cur_cnt[l] == '0);
  end
  assign free_empty = (cur_cnt[POOL] == '0);

  // Input rule: kinds alternate on back-to-back cycles
  p_alternate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && s1_vld) |-> (op_kind_e'(op_kind) != s1_kind));

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({deq_valid, deq_miss, enq_drop}));

  p_outcome_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid || deq_miss || enq_drop) |-> $past(op_valid, 2));

  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enq_drop |-> free_empty);

  p_miss_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deq_miss |-> ($stable(link_empty) && $stable(free_empty)));
endmodule

// File: tb/lq_mgr_tb.sv
module lq_mgr_tb;
  localparam int NL = 4;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_kind;
  logic [1:0]  op_link;
  logic [63:0] op_data;
  logic        deq_valid, deq_miss, enq_drop, free_empty;
  logic [63:0] deq_data;
  logic [3:0]  link_empty;

  always #2.5 clk = ~clk;

  lq_mgr #(.NUM_LINKS(NL), .SLOTS(NS), .DATA_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_link(op_link), .op_data(op_data), .deq_valid(deq_valid),
    .deq_miss(deq_miss), .deq_data(deq_data), .enq_drop(enq_drop),
    .link_empty(link_empty), .free_empty(free_empty)
  );

  int vectors = 0;
  int errors  = 0;

  // Reference model: one FIFO per link
  logic [63:0] mq [NL][NS];
  int rp [NL];
  int wp [NL];
  int mc [NL];
  int held;

  // Expectation pipeline, index 1 is the older entry
  logic        e_dv [2];
  logic        e_ms [2];
  logic        e_dr [2];
  logic [63:0] e_dt [2];
  logic [3:0]  e_le [2];
  logic        e_fe [2];

  task automatic cmp1(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp1(deq_valid, e_dv[1], e_dv[1] ? "R2" : "R4", "deq_valid");
    cmp1(deq_miss,  e_ms[1], "R5", "deq_miss");
    cmp1(enq_drop,  e_dr[1], "R6", "enq_drop");
    cmp1(free_empty, e_fe[1], "R7", "free_empty");
    vectors++;
    if (link_empty !== e_le[1]) begin
      errors++;
      $display("FAIL R9 link_empty actual=%b expected=%b", link_empty, e_le[1]);
    end
    if (e_dv[1]) begin
      vectors++;
      if (deq_data !== e_dt[1]) begin
        errors++;
        $display("FAIL R2 deq_data actual=%h expected=%h", deq_data, e_dt[1]);
      end
    end
  endtask

  // One cycle: check the op issued two cycles back, predict, drive.
  task automatic tick(input logic v, input logic k, input int l, input logic [63:0] d);
    @(negedge clk);
    check_outputs();
    e_dv[1] = e_dv[0]; e_ms[1] = e_ms[0]; e_dr[1] = e_dr[0];
    e_dt[1] = e_dt[0]; e_le[1] = e_le[0]; e_fe[1] = e_fe[0];
    e_dv[0] = 1'b0; e_ms[0] = 1'b0; e_dr[0] = 1'b0; e_dt[0] = '0;
    if (v) begin
      if (!k) begin
        if (held == NS) e_dr[0] = 1'b1;           // R6 drop when full
        else begin
          mq[l][wp[l]] = d; wp[l] = (wp[l] + 1) % NS; mc[l]++; held++;
        end
      end else begin
        if (mc[l] == 0) e_ms[0] = 1'b1;           // R5 miss on empty
        else begin
          e_dv[0] = 1'b1; e_dt[0] = mq[l][rp[l]];
          rp[l] = (rp[l] + 1) % NS; mc[l]--; held--;
        end
      end
    end
    for (int i = 0; i < NL; i++) e_le[0][i] = (mc[i] == 0);
    e_fe[0] = (held == NS);
    op_valid = v; op_kind = k; op_link = 2'(l); op_data = d;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 0, 64'h0);
  endtask

  function automatic logic [63:0] pat(input int l, input int ph, input int i);
    return {8'(l), 24'(ph), 32'(i) * 32'h9E37_79B9 + 32'(ph * 977)};
  endfunction

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 1'b0; op_link = '0; op_data = '0;
    held = 0;
    for (int i = 0; i < NL; i++) begin rp[i] = 0; wp[i] = 0; mc[i] = 0; end
    for (int j = 0; j < 2; j++) begin
      e_dv[j] = 1'b0; e_ms[j] = 1'b0; e_dr[j] = 1'b0; e_dt[j] = '0;
      e_le[j] = 4'hF; e_fe[j] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed over idle cycles
    repeat (3) idle();

    // R5: dequeue from every empty link
    for (int l = 0; l < NL; l++) begin tick(1'b1, 1'b1, l, '0); idle(); end

    // R10 and R3: enqueue, dequeue of another link, then the same link
    for (int l = 0; l < NL; l++) begin
      tick(1'b1, 1'b0, l, pat(l, 1, l));
      tick(1'b1, 1'b1, (l + 1) % NL, '0);
      idle();
      tick(1'b1, 1'b1, l, '0);
      idle();
    end
    for (int l = 0; l < NL; l++) begin
      tick(1'b1, 1'b0, l, pat(l, 2, l));
      tick(1'b1, 1'b1, l, '0);                    // R10 back to back
    end
    idle();

    // R7, R6, R8, R2: fill to overflow under three link distributions
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < NS + 2; i++) begin
        int l;
        l = (p == 0) ? i % NL : (p == 1) ? 2 : (i * i + i / 3) % NL;
        tick(1'b1, 1'b0, l, pat(l, 10 + p, i));
        idle();
      end
      for (int j = 0; j < 8; j++) begin         // R8 recycle, ports in turn
        tick(1'b1, 1'b1, j % NL, '0);
        tick(1'b1, 1'b0, (j + 1) % NL, pat(j, 20 + p, j));
      end
      idle();
      for (int r = 0; r < NS + 2; r++) begin
        for (int l = 0; l < NL; l++) begin tick(1'b1, 1'b1, l, '0); idle(); end
      end
    end

    // R10, R3: dense alternating stream across links
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0) tick(1'b1, 1'b0, (i / 2) % NL, pat(i % 7, 30, i));
      else            tick(1'b1, 1'b1, ((i / 2) + (i / 37)) % NL, '0);
    end
    repeat (3) idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule